// File: doc/BRIEF.md
# Eight-Point Multiplierless Forward DCT Pipeline

This block computes the one-dimensional forward discrete cosine transform of eight signed samples. It is meant to sit inside a larger image-transform datapath. All eight samples arrive together on one bus, qualified by a valid bit. All eight coefficients leave together after a fixed pipeline delay, and a valid bit marks the cycle in which they appear. Transposition and the second pass of a 2D transform belong to the surrounding logic.

The transform is factored into four dependent stages. The first stage forms mirrored sums and differences of the samples. The even half then splits again into its own even and odd parts. The odd half goes through two plane rotations, and a second set of butterflies follows them. Three rotations and two square-root-of-two scalings give eleven constant products in total. Each product is built from shifted adds and subtracts of signed-digit constants, and no hardware multiplier is used. Each rotation shares one product across both of its outputs. The odd path carries three guard bits until the final rounding, so each coefficient is rounded to the nearest integer about once.

Coefficient u is defined as sqrt(2) times the sum over n of x[n]·cos((2n+1)uπ/16) for u from 1 to 7. For u = 0 it is the plain sum of the samples.

Top module: `dct8_loeffler`

## Requirements
- R1: While rst_n is low, and after it rises until a newly accepted sample set has crossed the pipeline, out_valid is 0. A sample set that is in flight when reset is asserted never produces an out_valid pulse.
- R2: out_valid in any cycle equals in_valid five cycles earlier. A new sample set can be accepted every cycle, and results leave in the order the sets were accepted.
- R3: Coefficient 0 equals the exact integer sum of the eight samples.
- R4: Coefficient 4 equals (x0+x3+x4+x7) − (x1+x2+x5+x6) exactly.
- R5: Coefficients 2 and 6 lie within 2 LSB of sqrt(2)·Σ x[n]·cos((2n+1)uπ/16).
- R6: Coefficients 1, 3, 5 and 7 lie within 2 LSB of sqrt(2)·Σ x[n]·cos((2n+1)uπ/16).
- R7: While out_valid is 0, out_y keeps the last result unchanged. in_x is ignored in cycles where in_valid is 0.
- R8: Sample n is two's complement at in_x[n*IN_W +: IN_W]. Coefficient u is two's complement at out_y[u*OUT_W +: OUT_W].
- R9: Any inputs in the full range −256..255 give coefficients of magnitude at most 2050 with no wraparound. All samples at −256 give coefficient 0 = −2048.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Marks in_x as a sample set to transform |
| in_x | input | 8*IN_W | Eight packed two's-complement samples |
| out_valid | output | 1 | Marks out_y as a new coefficient set |
| out_y | output | 8*OUT_W | Eight packed two's-complement coefficients |

## Verification
A corrupted valid stage shows up at out_valid exactly five cycles after the sample it belongs to: the pulse is missing, doubled or shifted. A wrong constant, butterfly sign or rounding offset shows up in the very next coefficient word. Impulse vectors on single sample positions and alternating full-scale patterns isolate the coefficient path at fault. Coefficients 0 and 4 are exact, so any error in the first two butterfly stages shows there as an integer mismatch. A data register loading outside its valid stage shows up as out_y changing while out_valid is low.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

    localparam int NPT   = 8;   // points per transform
    localparam int CFRAC = 12;  // fractional bits of the constants
    localparam int GUARD = 3;   // extra fractional bits kept through the odd path

    // Constants rounded to CFRAC fractional bits.
    localparam int K_SQ2C6 = 2217;  // sqrt2*cos(6pi/16)
    localparam int K_SQ2S6 = 5352;  // sqrt2*sin(6pi/16)
    localparam int K_C3    = 3406;  // cos(3pi/16)
    localparam int K_S3    = 2276;  // sin(3pi/16)
    localparam int K_C1    = 4017;  // cos(pi/16)
    localparam int K_S1    = 799;   // sin(pi/16)
    localparam int K_SQ2   = 5793;  // sqrt2

    // Signed digit at position pos of the non-adjacent form of k (-1, 0, +1).
    function automatic int csd_digit(input int k, input int pos);
        int v;
        int d;
        v = (k < 0) ? -k : k;
        d = 0;
        for (int j = 0; j <= pos; j++) begin
            if ((v % 2) == 1) begin
                d = 2 - (v % 4);
                v = v - d;
            end else begin
                d = 0;
            end
            v = v / 2;
        end
        return (k < 0) ? -d : d;
    endfunction

endpackage

// File: rtl/dct8_csd_mul.sv
module dct8_csd_mul #(
    parameter int W      = 30,
    parameter int K      = 1,
    parameter int DIGITS = 16
) (
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] p
);

    logic signed [W-1:0] term [DIGITS];

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        localparam int D = dct8_pkg::csd_digit(K, i);
        if (D > 0) begin : g_pos
            assign term[i] = x <<< i;
        end else if (D < 0) begin : g_neg
            assign term[i] = -(x <<< i);
        end else begin : g_zero
            assign term[i] = '0;
        end
    end

    always_comb begin
        p = '0;
        for (int i = 0; i < DIGITS; i++) begin
            p = p + term[i];
        end
    end

endmodule

// File: rtl/dct8_rot.sv
module dct8_rot #(
    parameter int W  = 30,
    parameter int KC = 4096,
    parameter int KS = 0,
    parameter int SH = 12
) (
    input  logic signed [W-1:0] i0,
    input  logic signed [W-1:0] i1,
    output logic signed [W-1:0] o0,
    output logic signed [W-1:0] o1
);

    // o0 = KC*i0 + KS*i1 ; o1 = KC*i1 - KS*i0 ; with KC*(i0+i1) shared
    localparam int KDIF = KC - KS;
    localparam int KSUM = KC + KS;
    localparam logic signed [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic signed [W-1:0] HALF = ONE <<< (SH - 1);

    logic signed [W-1:0] pair_sum;
    logic signed [W-1:0] m_shared;
    logic signed [W-1:0] m_i1;
    logic signed [W-1:0] m_i0;

    assign pair_sum = i0 + i1;

    dct8_csd_mul #(.W(W), .K(KC))   u_shared (.x(pair_sum), .p(m_shared));
    dct8_csd_mul #(.W(W), .K(KDIF)) u_dif    (.x(i1),       .p(m_i1));
    dct8_csd_mul #(.W(W), .K(KSUM)) u_sum    (.x(i0),       .p(m_i0));

    assign o0 = (m_shared - m_i1 + HALF) >>> SH;
    assign o1 = (m_shared - m_i0 + HALF) >>> SH;

endmodule

// File: rtl/dct8_loeffler.sv
module dct8_loeffler
    import dct8_pkg::*;
#(
    parameter int IN_W  = 9,
    parameter int OUT_W = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [NPT*IN_W-1:0]   in_x,
    output logic                  out_valid,
    output logic [NPT*OUT_W-1:0]  out_y
);

    localparam int W     = IN_W + CFRAC + GUARD + 6;
    localparam int DEPTH = 5;
    localparam int SH_OD = CFRAC - GUARD;
    localparam logic signed [W-1:0] ONE    = {{(W-1){1'b0}}, 1'b1};
    localparam logic signed [W-1:0] GHALF  = ONE <<< (GUARD - 1);
    localparam logic signed [W-1:0] OHALF  = ONE <<< (CFRAC + GUARD - 1);
    localparam logic signed [W-1:0] SAT_HI = (ONE <<< (OUT_W - 1)) - ONE;
    localparam logic signed [W-1:0] SAT_LO = -(ONE <<< (OUT_W - 1));

    // valid pipeline
    logic [DEPTH-1:0] vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            vld <= {vld[DEPTH-2:0], in_valid};
        end
    end

    assign out_valid = vld[DEPTH-1];

    // stage 0: input register
    logic signed [W-1:0] x_q [NPT];

    always_ff @(posedge clk) begin
        if (in_valid) begin
            for (int n = 0; n < NPT; n++) begin
                x_q[n] <= {{(W-IN_W){in_x[n*IN_W+IN_W-1]}}, in_x[n*IN_W +: IN_W]};
            end
        end
    end

    // stage 1: mirrored butterflies
    logic signed [W-1:0] a_c [NPT];
    logic signed [W-1:0] a_q [NPT];

    always_comb begin
        for (int n = 0; n < NPT/2; n++) begin
            a_c[n]       = x_q[n] + x_q[NPT-1-n];
            a_c[NPT-1-n] = x_q[n] - x_q[NPT-1-n];
        end
    end

    always_ff @(posedge clk) begin
        if (vld[0]) a_q <= a_c;
    end

    // stage 2: even butterflies, odd rotations (guard bits kept)
    logic signed [W-1:0] b_c [4];
    logic signed [W-1:0] b_q [4];
    logic signed [W-1:0] e4_w, e5_w, e6_w, e7_w;
    logic signed [W-1:0] e_q [4];

    always_comb begin
        b_c[0] = a_q[0] + a_q[3];
        b_c[1] = a_q[1] + a_q[2];
        b_c[2] = a_q[1] - a_q[2];
        b_c[3] = a_q[0] - a_q[3];
    end

    dct8_rot #(.W(W), .KC(K_C3), .KS(K_S3), .SH(SH_OD)) u_rot_c3 (
        .i0(a_q[4]), .i1(a_q[7]), .o0(e4_w), .o1(e7_w)
    );

    dct8_rot #(.W(W), .KC(K_C1), .KS(K_S1), .SH(SH_OD)) u_rot_c1 (
        .i0(a_q[5]), .i1(a_q[6]), .o0(e5_w), .o1(e6_w)
    );

    always_ff @(posedge clk) begin
        if (vld[1]) begin
            b_q    <= b_c;
            e_q[0] <= e4_w;
            e_q[1] <= e5_w;
            e_q[2] <= e6_w;
            e_q[3] <= e7_w;
        end
    end

    // stage 3: even outputs final, odd second butterflies
    // slots: 0 Y0, 2 Y2, 4 Y4, 6 Y6, 1 p, 3 t, 5 q, 7 r
    logic signed [W-1:0] y2_w, y6_w;
    logic signed [W-1:0] s3_c [NPT];
    logic signed [W-1:0] s3_q [NPT];

    dct8_rot #(.W(W), .KC(K_SQ2C6), .KS(K_SQ2S6), .SH(CFRAC)) u_rot_c6 (
        .i0(b_q[2]), .i1(b_q[3]), .o0(y2_w), .o1(y6_w)
    );

    always_comb begin
        s3_c[0] = b_q[0] + b_q[1];
        s3_c[4] = b_q[0] - b_q[1];
        s3_c[2] = y2_w;
        s3_c[6] = y6_w;
        s3_c[1] = e_q[0] + e_q[2];
        s3_c[5] = e_q[0] - e_q[2];
        s3_c[7] = e_q[3] + e_q[1];
        s3_c[3] = e_q[3] - e_q[1];
    end

    always_ff @(posedge clk) begin
        if (vld[2]) s3_q <= s3_c;
    end

    // stage 4: odd rounding and sqrt2 scaling, saturation, output register
    logic signed [W-1:0] m3_w, m5_w;
    logic signed [W-1:0] y_c [NPT];
    logic signed [OUT_W-1:0] y_s [NPT];
    logic signed [OUT_W-1:0] y_q [NPT];

    dct8_csd_mul #(.W(W), .K(K_SQ2)) u_sq2_y3 (.x(s3_q[3]), .p(m3_w));
    dct8_csd_mul #(.W(W), .K(K_SQ2)) u_sq2_y5 (.x(s3_q[5]), .p(m5_w));

    always_comb begin
        y_c[0] = s3_q[0];
        y_c[2] = s3_q[2];
        y_c[4] = s3_q[4];
        y_c[6] = s3_q[6];
        y_c[1] = (s3_q[7] + s3_q[1] + GHALF) >>> GUARD;
        y_c[7] = (s3_q[7] - s3_q[1] + GHALF) >>> GUARD;
        y_c[3] = (m3_w + OHALF) >>> (CFRAC + GUARD);
        y_c[5] = (m5_w + OHALF) >>> (CFRAC + GUARD);
    end

    always_comb begin
        for (int u = 0; u < NPT; u++) begin
            if (y_c[u] > SAT_HI) begin
                y_s[u] = SAT_HI[OUT_W-1:0];
            end else if (y_c[u] < SAT_LO) begin
                y_s[u] = SAT_LO[OUT_W-1:0];
            end else begin
                y_s[u] = y_c[u][OUT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (vld[3]) y_q <= y_s;
    end

    always_comb begin
        for (int u = 0; u < NPT; u++) begin
            out_y[u*OUT_W +: OUT_W] = y_q[u];
        end
    end

endmodule

// File: rtl/dct8_loeffler_chk.sv
module dct8_loeffler_chk #(
    parameter int OUT_W = 14,
    parameter int DEPTH = 5,
    parameter int BOUND = 2050
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               out_valid,
    input logic [8*OUT_W-1:0] out_y
);

    logic [DEPTH-1:0] acc_hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_hist <= '0;
        end else begin
            acc_hist <= {acc_hist[DEPTH-2:0], in_valid};
        end
    end

    always_comb begin
        if (!rst_n) begin
            a_r1_idle_in_reset: assert (out_valid == 1'b0);
        end
    end

    a_r2_valid_delay: assert property (
        @(posedge clk) disable iff (!rst_n) out_valid == acc_hist[DEPTH-1]
    );

    a_r7_hold_when_idle: assert property (
        @(posedge clk) disable iff (!rst_n) !out_valid |-> $stable(out_y)
    );

    for (genvar u = 0; u < 8; u++) begin : g_rng
        a_r9_no_overflow: assert property (
            @(posedge clk) disable iff (!rst_n)
            out_valid |-> ($signed(out_y[u*OUT_W +: OUT_W]) <= BOUND &&
                           $signed(out_y[u*OUT_W +: OUT_W]) >= -BOUND)
        );
    end

endmodule

bind dct8_loeffler dct8_loeffler_chk #(.OUT_W(OUT_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .out_valid(out_valid), .out_y(out_y)
);

// File: tb/dct8_loeffler_tb.sv
`timescale 1ns/1ps
module dct8_loeffler_tb;

    localparam int IN_W  = 9;
    localparam int OUT_W = 14;
    localparam int NPT   = 8;
    localparam int DEPTH = 5;
    localparam real PI   = 3.14159265358979323846;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 in_valid;
    logic [NPT*IN_W-1:0]  in_x;
    logic                 out_valid;
    logic [NPT*OUT_W-1:0] out_y;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;
    int seed = 32'h1234_5678;

    always #2 clk = ~clk;

    dct8_loeffler #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .out_valid(out_valid), .out_y(out_y)
    );

    function automatic real ref_coef(input int u, input int v[8]);
        real s;
        s = 0.0;
        for (int n = 0; n < NPT; n++) s = s + v[n] * $cos((2*n + 1) * u * PI / 16.0);
        return (u == 0) ? s : s * $sqrt(2.0);
    endfunction

    function automatic int coef(input int u);
        logic signed [OUT_W-1:0] c;
        c = out_y[u*OUT_W +: OUT_W];
        return int'(c);
    endfunction

    function int rnd_sample();
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 16) & 511) - 256;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_near(input string req, input int u, input int act, input real exp);
        real d;
        n_checks++;
        d = act - exp;
        if (d > 2.0 || d < -2.0) begin
            n_errors++;
            $display("FAIL %s coef %0d: actual %0d expected %f", req, u, act, exp);
        end
    endtask

    task automatic apply(input int v[8]);
        for (int n = 0; n < NPT; n++) in_x[n*IN_W +: IN_W] = IN_W'(v[n]);
    endtask

    // R3/R4 exact, R5 even rotation, R6 odd path; positions per R8
    task automatic check_result(input int v[8]);
        int s;
        int d4;
        s  = 0;
        d4 = 0;
        for (int n = 0; n < NPT; n++) begin
            s = s + v[n];
            d4 = d4 + (((n == 0) || (n == 3) || (n == 4) || (n == 7)) ? v[n] : -v[n]);
        end
        check_eq("R3", "Y0", coef(0), s);
        check_eq("R4", "Y4", coef(4), d4);
        check_near("R5", 2, coef(2), ref_coef(2, v));
        check_near("R5", 6, coef(6), ref_coef(6, v));
        check_near("R6", 1, coef(1), ref_coef(1, v));
        check_near("R6", 3, coef(3), ref_coef(3, v));
        check_near("R6", 5, coef(5), ref_coef(5, v));
        check_near("R6", 7, coef(7), ref_coef(7, v));
    endtask

    task automatic run_single(input int v[8]);
        @(negedge clk);
        apply(v);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (DEPTH - 2) @(negedge clk);
        check_eq("R2", "valid early", int'(out_valid), 0);
        @(negedge clk);
        check_eq("R2", "valid at latency", int'(out_valid), 1);
        check_result(v);
        @(negedge clk);
        check_eq("R2", "single pulse", int'(out_valid), 0);
    endtask

    task automatic t_reset();
        int v[8];
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_x = '0;
        repeat (3) @(negedge clk);
        check_eq("R1", "valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "valid after release", int'(out_valid), 0);
        for (int n = 0; n < NPT; n++) v[n] = 10 * n;
        apply(v);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH + 2; i++) begin
            @(negedge clk);
            check_eq("R1", "flight dropped", int'(out_valid), 0);
        end
    endtask

    task automatic t_patterns();
        int v[8];
        for (int n = 0; n < NPT; n++) v[n] = 0;
        run_single(v);
        for (int n = 0; n < NPT; n++) v[n] = 100;
        run_single(v);
        for (int n = 0; n < NPT; n++) v[n] = (n == 2) ? 200 : ((n == 5) ? -150 : 0);
        run_single(v);  // R8 single-position impulses
        for (int n = 0; n < NPT; n++) v[n] = 30 * n - 100;
        run_single(v);
        for (int k = 0; k < 6; k++) begin
            for (int n = 0; n < NPT; n++) v[n] = rnd_sample();
            run_single(v);
        end
    endtask

    task automatic t_full_scale();
        int v[8];
        for (int n = 0; n < NPT; n++) v[n] = -256;
        run_single(v);
        check_eq("R9", "Y0 all min", coef(0), -2048);
        for (int n = 0; n < NPT; n++) v[n] = 255;
        run_single(v);
        for (int n = 0; n < NPT; n++) v[n] = (n % 2 == 0) ? 255 : -256;
        run_single(v);
        for (int n = 0; n < NPT; n++) v[n] = (n == 0 || n == 3 || n == 4 || n == 7) ? -256 : 255;
        run_single(v);
        check_eq("R9", "Y4 extreme", coef(4), -2044);
    endtask

    task automatic t_stream();
        int vs[8][8];
        for (int k = 0; k < 8; k++)
            for (int n = 0; n < NPT; n++) vs[k][n] = rnd_sample();
        for (int i = 0; i <= 8 + DEPTH; i++) begin
            @(negedge clk);
            if (i >= DEPTH && i - DEPTH < 8) begin
                check_eq("R2", "stream valid", int'(out_valid), 1);
                check_result(vs[i - DEPTH]);
            end
            if (i == 8 + DEPTH) check_eq("R2", "stream end", int'(out_valid), 0);
            if (i < 8) begin
                apply(vs[i]);
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic t_hold();
        int v[8];
        logic [NPT*OUT_W-1:0] kept;
        for (int n = 0; n < NPT; n++) v[n] = 7 - 3 * n;
        run_single(v);
        kept = out_y;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            in_x = {NPT{9'h155}} ^ (NPT*IN_W)'(i * 77);
            check_eq("R7", "no valid while idle", int'(out_valid), 0);
            n_checks++;
            if (out_y !== kept) begin
                n_errors++;
                $display("FAIL R7 hold: actual %h expected %h", out_y, kept);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_patterns();
        t_full_scale();
        t_stream();
        t_hold();
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule